// File: doc/BRIEF.md
# Standby Mode Controller

This block decides when the CPU clock may run. Software puts the CPU into one of two low-power modes by writing an 8-bit control register. In the light mode, HALT, only the CPU clock is gated. In the deep mode, STOP, the block can also float the output pads and shut down the main oscillator. Entering STOP takes two steps. Software first writes a 1 to a separate stop-code acceptor path, which arms the entry. The STOP write that follows then takes effect. The two modes end on different events. An interrupt or the external reset pin ends either one. A watchdog overflow ends HALT but is ignored during STOP.

The mode is held in a three-state machine: `ST_RUN`, `ST_HALT` and `ST_STOP`. These are its transitions:
- `ST_RUN` to `ST_STOP`: an armed STOP write.
- `ST_RUN` to `ST_HALT`: a HALT write.
- `ST_HALT` to `ST_RUN`: an interrupt or a watchdog overflow.
- `ST_STOP` to `ST_RUN`: an interrupt.
- Any state to `ST_RUN`: the asynchronous external reset.

When a watchdog overflow is honoured (any state except `ST_STOP`), it also restores the register's reset value. The readback places the STOP flag at bit 0 and the HALT flag at bit 1. The pad-float option is at bit 2. The oscillator-keep option is at bit 3.

Top module: `stby_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `reg_rdata` reads 08h. Both mode flags are 0, `cpu_clk_en` and `main_osc_en` are 1, `out_float_en` is 0, and the acceptor is disarmed.
- R2: Bits 7..4 of `reg_rdata` always read 0, and writes to them have no effect. Bits 2 and 3 read back the value last written. A write with `reg_sel` low changes nothing.
- R3: A bus write with bit 0 = 1 while the acceptor is armed and the block is in RUN enters STOP at the next clock edge. `reg_rdata[0]` and `stop_mode` then read 1.
- R4: A bus write with bit 0 = 1 while the acceptor is not armed does not enter STOP, and `reg_rdata[0]` stays 0.
- R5: A bus write with bit 0 = 1 disarms the acceptor whether or not STOP was entered. If an arm write and such a bus write fall in the same cycle, the bus write does not enter STOP and the acceptor is armed afterwards.
- R6: A bus write with bit 1 = 1 in RUN enters HALT (`reg_rdata[1]` = 1), unless the same write enters STOP, which wins.
- R7: An interrupt ends STOP at the next edge, and so does `rst_n`. A `wdt_rst` pulse during STOP has no effect on the register or the mode.
- R8: An interrupt ends HALT, and so does `rst_n` or `wdt_rst`. A `wdt_rst` pulse outside STOP returns the register to 08h and disarms the acceptor.
- R9: While `irq` is high in RUN, a write to bit 0 or bit 1 does not enter a standby mode.
- R10: `cpu_clk_en` is 0 exactly while bit 0 or bit 1 reads 1.
- R11: `out_float_en` is 1 exactly while bit 2 = 1 and the block is in STOP.
- R12: `main_osc_en` is 0 only while in STOP with `subclk_sel` = 1 and bit 3 = 0. It is 1 otherwise.
- R13: In HALT or STOP, a bus write leaves bits 0 and 1 unchanged, even with the acceptor armed. It still updates bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| reg_we | input | 1 | Register bus write strobe |
| reg_sel | input | 1 | Register address select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| acp_wr | input | 1 | Stop-code acceptor write strobe |
| acp_wdata | input | 1 | Acceptor write value (1 arms, 0 disarms) |
| irq | input | 1 | Interrupt request, ends either standby mode |
| wdt_rst | input | 1 | Watchdog overflow reset pulse, synchronous |
| subclk_sel | input | 1 | High when the subclock drives the CPU |
| stop_mode | output | 1 | STOP mode active |
| halt_mode | output | 1 | HALT mode active |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| out_float_en | output | 1 | Output pads to high impedance |
| main_osc_en | output | 1 | Main oscillator enable |

## Verification
Every one of the 256 write values is tried once with the acceptor armed and once without it. The subclock flag alternates across the sweep. This separates STOP entry from HALT entry and from ignored mode bits, and it exposes each of the float and oscillator qualifiers. Directed sequences then target the release paths:
- interrupt versus watchdog during STOP, and during HALT;
- an arm write that coincides with a STOP write;
- an interrupt that coincides with a mode write;
- writes made while already in a standby mode.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STOP = 2'd2
    } stby_state_e;

    // Field positions decoded by neighbouring logic
    localparam int STP_POS   = 0;
    localparam int HLT_POS   = 1;
    localparam int FLT_POS   = 2;
    localparam int OSC_POS   = 3;
    localparam int CTRL_BITS = 4;

    // Reset values of the stored option bits (register reads 08h)
    localparam logic FLT_RST = 1'b0;
    localparam logic OSC_RST = 1'b1;

endpackage

// File: rtl/stby_acceptor.sv
module stby_acceptor (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_clr,
    input  logic arm_wr,
    input  logic arm_val,
    input  logic attempt,
    output logic armed
);

    logic armed_q;

    // An explicit arm write beats a same-cycle attempt; any attempt otherwise consumes the arm.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (sync_clr) begin
            armed_q <= 1'b0;
        end else if (arm_wr) begin
            armed_q <= arm_val;
        end else if (attempt) begin
            armed_q <= 1'b0;
        end
    end

    assign armed = armed_q;

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wdt_eff,
    input  logic        irq,
    input  logic        wr_en,
    input  logic        stp_req,
    input  logic        hlt_req,
    input  logic        armed,
    output stby_state_e state
);

    stby_state_e state_q;
    stby_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wdt_eff || irq) begin
                    state_d = ST_RUN;
                end else if (wr_en && stp_req && armed) begin
                    state_d = ST_STOP;
                end else if (wr_en && hlt_req) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (irq || wdt_eff) begin
                    state_d = ST_RUN;
                end
            end
            ST_STOP: begin
                if (irq) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/stby_cfg_reg.sv
module stby_cfg_reg
    import stby_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              flt,
    output logic              oscs
);

    logic flt_q;
    logic oscs_q;
    logic unused_hi_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q  <= FLT_RST;
            oscs_q <= OSC_RST;
        end else if (sync_clr) begin
            flt_q  <= FLT_RST;
            oscs_q <= OSC_RST;
        end else if (wr_en) begin
            flt_q  <= wdata[FLT_POS];
            oscs_q <= wdata[OSC_POS];
        end
    end

    // Upper data bits and mode bits are not stored here
    assign unused_hi_bits = ^{wdata[DATA_W-1:CTRL_BITS], wdata[HLT_POS], wdata[STP_POS]};

    assign flt  = flt_q;
    assign oscs = oscs_q;

endmodule

// File: rtl/stby_outq.sv
module stby_outq
    import stby_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  stby_state_e       state,
    input  logic              flt,
    input  logic              oscs,
    input  logic              subclk_sel,
    output logic              stop_mode,
    output logic              halt_mode,
    output logic              cpu_clk_en,
    output logic              out_float_en,
    output logic              main_osc_en,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - CTRL_BITS;

    always_comb begin
        stop_mode = 1'b0;
        halt_mode = 1'b0;
        unique case (state)
            ST_RUN:  ;
            ST_HALT: halt_mode = 1'b1;
            ST_STOP: stop_mode = 1'b1;
            default: ;
        endcase
        cpu_clk_en   = !(stop_mode || halt_mode);
        out_float_en = stop_mode && flt;
        main_osc_en  = !(stop_mode && subclk_sel && !oscs);
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata = {{PAD_W{1'b0}}, oscs, flt, halt_mode, stop_mode};
        end else begin : g_nopad
            assign rdata = {oscs, flt, halt_mode, stop_mode};
        end
    endgenerate

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              acp_wr,
    input  logic              acp_wdata,
    input  logic              irq,
    input  logic              wdt_rst,
    input  logic              subclk_sel,
    output logic              stop_mode,
    output logic              halt_mode,
    output logic              cpu_clk_en,
    output logic              out_float_en,
    output logic              main_osc_en
);

    stby_state_e state;
    logic        wr_en;
    logic        wdt_eff;
    logic        attempt;
    logic        acp_armed;
    logic        flt;
    logic        oscs;

    assign wr_en   = reg_we && reg_sel;
    // Watchdog is frozen while in STOP
    assign wdt_eff = wdt_rst && (state != ST_STOP);
    assign attempt = wr_en && reg_wdata[STP_POS];

    stby_acceptor u_acp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (wdt_eff),
        .arm_wr   (acp_wr),
        .arm_val  (acp_wdata),
        .attempt  (attempt),
        .armed    (acp_armed)
    );

    stby_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wdt_eff (wdt_eff),
        .irq     (irq),
        .wr_en   (wr_en),
        .stp_req (reg_wdata[STP_POS]),
        .hlt_req (reg_wdata[HLT_POS]),
        .armed   (acp_armed),
        .state   (state)
    );

    stby_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (wdt_eff),
        .wr_en    (wr_en),
        .wdata    (reg_wdata),
        .flt      (flt),
        .oscs     (oscs)
    );

    stby_outq #(.DATA_W(DATA_W)) u_outq (
        .state        (state),
        .flt          (flt),
        .oscs         (oscs),
        .subclk_sel   (subclk_sel),
        .stop_mode    (stop_mode),
        .halt_mode    (halt_mode),
        .cpu_clk_en   (cpu_clk_en),
        .out_float_en (out_float_en),
        .main_osc_en  (main_osc_en),
        .rdata        (reg_rdata)
    );

endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              wdt_rst,
    input logic              subclk_sel,
    input logic              armed,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              stop_mode,
    input logic              halt_mode,
    input logic              cpu_clk_en,
    input logic              out_float_en,
    input logic              main_osc_en
);

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:4] == '0);

    // R3
    stop_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_mode) |-> $past(armed));

    // R5
    stop_consumes_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_mode) |-> !armed);

    // R7
    stop_irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && irq) |=> !stop_mode);

    // R7
    stop_wdt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && wdt_rst && !irq) |=> (stop_mode && $stable(reg_rdata)));

    // R8
    halt_wdt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_mode && wdt_rst) |=> (!halt_mode && reg_rdata == 8'h08));

    // R9
    irq_blocks_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_mode && !halt_mode && irq) |=> (!stop_mode && !halt_mode));

    // R10
    clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en == (reg_rdata[1:0] == 2'b00));

    // R11
    float_only_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_float_en |-> (reg_rdata[0] && reg_rdata[2]));

    // R12
    osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_osc_en |-> (stop_mode && subclk_sel && !reg_rdata[3]));

    // R6
    modes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stop_mode, halt_mode}));

endmodule

bind stby_ctrl stby_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq          (irq),
    .wdt_rst      (wdt_rst),
    .subclk_sel   (subclk_sel),
    .armed        (acp_armed),
    .reg_rdata    (reg_rdata),
    .stop_mode    (stop_mode),
    .halt_mode    (halt_mode),
    .cpu_clk_en   (cpu_clk_en),
    .out_float_en (out_float_en),
    .main_osc_en  (main_osc_en)
);

// File: tb/stby_ctrl_bench.sv
`timescale 1ns/1ps
module stby_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       acp_wr = 1'b0;
    logic       acp_wdata = 1'b0;
    logic       irq = 1'b0;
    logic       wdt_rst = 1'b0;
    logic       subclk_sel = 1'b0;
    logic       stop_mode, halt_mode, cpu_clk_en, out_float_en, main_osc_en;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    stby_ctrl u_stby_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acp_wr(acp_wr),
        .acp_wdata(acp_wdata), .irq(irq), .wdt_rst(wdt_rst),
        .subclk_sel(subclk_sel), .stop_mode(stop_mode), .halt_mode(halt_mode),
        .cpu_clk_en(cpu_clk_en), .out_float_en(out_float_en),
        .main_osc_en(main_osc_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic arm();
        acp_wr = 1'b1; acp_wdata = 1'b1;
        @(negedge clk);
        acp_wr = 1'b0; acp_wdata = 1'b0;
    endtask

    task automatic bus_wr(input logic [7:0] v);
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic pulse_irq();
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    task automatic pulse_wdt();
        wdt_rst = 1'b1;
        @(negedge clk);
        wdt_rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: values held during reset
        check("R1 rdata in reset", reg_rdata, 8'h08);
        check("R1 clk en in reset", cpu_clk_en, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep of all write values, armed and unarmed
        for (int v = 0; v < 256; v++) begin
            for (int a = 0; a < 2; a++) begin
                logic [7:0] w;
                logic stp, hlt, sub;
                logic [7:0] exp_rd;
                w = v[7:0];
                do_reset();
                check("R1 rdata after reset", reg_rdata, 8'h08);
                check("R1 outputs after reset",
                      {stop_mode, halt_mode, cpu_clk_en, out_float_en, main_osc_en}, 5'b00101);
                sub = w[5] ^ a[0];
                subclk_sel = sub;
                if (a == 1) arm();
                bus_wr(w);
                stp = a[0] & w[0];
                hlt = w[1] & !stp;
                exp_rd = {4'b0000, w[3], w[2], hlt, stp};
                check("R2 R3 R4 R6 readback", reg_rdata, exp_rd);
                check("R10 cpu clock gate", cpu_clk_en, !(stp || hlt));
                check("R11 float enable", out_float_en, w[2] & stp);
                check("R12 main osc enable", main_osc_en, !(stp && sub && !w[3]));
                if (stp || hlt) begin
                    pulse_irq();
                    check("R7 R8 irq release", {reg_rdata[1:0], cpu_clk_en}, 3'b001);
                end
                if (w[0]) begin
                    bus_wr(8'h09);
                    check("R5 arm consumed", reg_rdata, 8'h08);
                end
            end
        end

        // R2: write without select ignored
        do_reset();
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h06;
        @(negedge clk);
        reg_we = 1'b0;
        check("R2 unselected write", reg_rdata, 8'h08);

        // R9: irq concurrent with armed STOP write and with HALT write
        do_reset();
        arm();
        irq = 1'b1;
        bus_wr(8'h09);
        irq = 1'b0;
        check("R9 irq blocks stop", reg_rdata, 8'h08);
        irq = 1'b1;
        bus_wr(8'h0A);
        irq = 1'b0;
        check("R9 irq blocks halt", reg_rdata, 8'h08);

        // R7: watchdog ignored in STOP, reset pin releases
        do_reset();
        arm();
        bus_wr(8'h0D);
        check("R3 stop entered", {reg_rdata, stop_mode}, {8'h0D, 1'b1});
        pulse_wdt();
        check("R7 wdt ignored in stop", {reg_rdata, stop_mode}, {8'h0D, 1'b1});
        do_reset();
        check("R7 reset pin releases stop", {reg_rdata, stop_mode}, {8'h08, 1'b0});

        // R8: watchdog releases HALT and restores register
        do_reset();
        bus_wr(8'h06);
        check("R6 halt entered", {reg_rdata, halt_mode}, {8'h06, 1'b1});
        pulse_wdt();
        check("R8 wdt releases halt", {reg_rdata, halt_mode, cpu_clk_en}, {8'h08, 1'b0, 1'b1});
        arm();
        pulse_wdt();
        bus_wr(8'h09);
        check("R8 wdt disarms", reg_rdata, 8'h08);

        // R13: writes while in HALT keep mode bits, update options
        do_reset();
        bus_wr(8'h02);
        arm();
        bus_wr(8'h0D);
        check("R13 halt write", {reg_rdata, stop_mode, halt_mode}, {8'h0E, 1'b0, 1'b1});
        // R13: writes while in STOP
        do_reset();
        arm();
        bus_wr(8'h01);
        bus_wr(8'h0E);
        check("R13 stop write", {reg_rdata, stop_mode}, {8'h0D, 1'b1});
        check("R11 float in stop", out_float_en, 1'b1);

        // R5: same-cycle arm and attempt
        do_reset();
        acp_wr = 1'b1; acp_wdata = 1'b1;
        bus_wr(8'h01);
        acp_wr = 1'b0; acp_wdata = 1'b0;
        check("R5 same-cycle attempt fails", reg_rdata, 8'h00);
        bus_wr(8'h01);
        check("R5 arm survives same-cycle", reg_rdata, 8'h01);

        // R12: oscillator follows subclock flag in STOP
        subclk_sel = 1'b1;
        @(negedge clk);
        check("R12 osc off with subclk", main_osc_en, 1'b0);
        subclk_sel = 1'b0;
        @(negedge clk);
        check("R12 osc on without subclk", main_osc_en, 1'b1);

        // R6: armed STOP beats HALT in the same write
        do_reset();
        arm();
        bus_wr(8'h0B);
        check("R6 stop wins over halt", {reg_rdata, stop_mode, halt_mode}, {8'h09, 1'b1, 1'b0});

        finish_run();
    end

endmodule